// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block receives stereo PCM samples from a three-wire serial audio port: a bit clock, a left/right frame clock and one data line. It decodes I2S, left-justified and right-justified framing, with a word length that can be set anywhere from 16 to 24 bits. Each completed word comes out as a signed value left-aligned in a 24-bit bus, together with a one-cycle strobe for its channel.

The block runs on a fast system clock. It samples the bit clock, frame clock and data through matched synchronisers and acts on each rising bit-clock edge it detects. As clock master it makes the bit clock by integer division of the system clock, at 64 bit clocks per frame. It drives both clock pins and reads them back through the same path. Both pins can be released to high impedance, so another transmitter can drive a shared clock bus, and the receiver then follows those external clocks.

Top module: `pcm_serial_rx`

## Requirements
- R1: `rj_en`=1 selects right-justified framing. With `rj_en`=0, `fmt_i2s`=1 selects I2S and `fmt_i2s`=0 selects left-justified.
- R2: In I2S, the MSB is the bit sampled on the second rising bit-clock edge after a frame-clock change. The word is left channel while the frame clock is low.
- R3: In left-justified framing, the MSB is the bit sampled on the first rising bit-clock edge after a frame-clock change. The word is left channel while the frame clock is high.
- R4: In right-justified framing, the LSB is the last bit before the next frame-clock change, and bits ahead of the word are ignored. The frame clock high means left channel. The word is emitted at the first rising bit-clock edge of the following half, and only if the half it came from began with a detected frame-clock change.
- R5: The word length W comes from `wlen`. Values below 16 act as 16 and values above 24 act as 24. Bits in a half outside the W-bit word have no effect.
- R6: Output data is the W-bit word placed in bits 23 down to 24-W, with the remaining low bits zero. Each strobe is high for one system cycle, and the two channel strobes are never high together.
- R7: A strobe and its data appear in the third system cycle after the system edge that first captures the rising bit-clock edge carrying the triggering bit.
- R8: When driving clocks (`master_en`=1, `clk_hiz`=0), the bit clock period is 2*HALF_DIV system cycles. Both clocks are low in reset. The frame clock changes only on a falling bit-clock edge, once every 32 bit clocks.
- R9: With `clk_hiz`=1 or `master_en`=0, both clock pins are left undriven and the receiver decodes from the externally driven clocks.
- R10: No strobe is raised during reset, and no strobe is raised before the first frame-clock change after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_en | input | 1 | Drive the bit and frame clocks |
| clk_hiz | input | 1 | Release both clock pins to high impedance |
| fmt_i2s | input | 1 | 1 = I2S, 0 = left-justified (when rj_en is 0) |
| rj_en | input | 1 | Right-justified framing |
| wlen | input | 5 | Word length, effective range 16 to 24 |
| bclk | inout | 1 | Serial bit clock |
| lrck | inout | 1 | Left/right frame clock |
| sdata | input | 1 | Serial data |
| left_data | output | 24 | Left sample, left-aligned |
| left_valid | output | 1 | Left sample strobe |
| right_data | output | 24 | Right sample, left-aligned |
| right_valid | output | 1 | Right sample strobe |

## Verification
Every word is due exactly three system cycles after the bench raises the bit clock carrying the triggering bit. That bit is the LSB for I2S and left-justified framing, and the first bit of the next half for right-justified framing. The bench records the cycle of each rising edge it drives and queues the expected channel and value for that cycle plus three. On every clock it compares both strobes and both data buses against the queue head, so a strobe that comes early, late, on the wrong channel or with no expected word fails. In master mode the bench measures bit-clock rise spacing and frame-clock toggles directly on the pins.

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx #(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        master_en,
  input  logic        clk_hiz,
  input  logic        fmt_i2s,
  input  logic        rj_en,
  input  logic [4:0]  wlen,
  inout  wire         bclk,
  inout  wire         lrck,
  input  logic        sdata,
  output logic [23:0] left_data,
  output logic        left_valid,
  output logic [23:0] right_data,
  output logic        right_valid
);
  localparam int DIVW = $clog2(HALF_DIV + 1);

  logic            drive;
  logic [DIVW-1:0] div_cnt;
  logic            bclk_q;
  logic [5:0]      bcnt;

  assign drive = master_en & ~clk_hiz;
  assign bclk  = drive ? bclk_q  : 1'bz;
  assign lrck  = drive ? bcnt[5] : 1'bz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      bclk_q  <= 1'b0;
      bcnt    <= '0;
    end else if (div_cnt == DIVW'(HALF_DIV - 1)) begin
      div_cnt <= '0;
      bclk_q  <= ~bclk_q;
      if (bclk_q) bcnt <= bcnt + 6'd1;
    end else begin
      div_cnt <= div_cnt + DIVW'(1);
    end
  end

  logic [2:0]  bc_sy;
  logic [1:0]  lr_sy, d_sy;
  logic        rise, lr_now, d_now, frame_edge;
  logic        lr_prev, seen;
  logic [5:0]  pos, pos_now;
  logic [23:0] sh, full_cur, word;
  logic [4:0]  wl, shamt;
  logic        is_i2s, is_lj, done, emit_left;

  assign rise       = bc_sy[1] & ~bc_sy[2];
  assign lr_now     = lr_sy[1];
  assign d_now      = d_sy[1];
  assign frame_edge = lr_now ^ lr_prev;
  assign pos_now    = frame_edge ? 6'd0 : ((pos == 6'd63) ? pos : pos + 6'd1);
  assign full_cur   = {sh[22:0], d_now};

  assign wl     = (wlen < 5'd16) ? 5'd16 : ((wlen > 5'd24) ? 5'd24 : wlen);
  assign shamt  = 5'd24 - wl;
  assign is_i2s = ~rj_en & fmt_i2s;
  assign is_lj  = ~rj_en & ~fmt_i2s;

  assign done = rise & ((is_lj  && pos_now == {1'b0, wl} - 6'd1) ||
                        (is_i2s && pos_now == {1'b0, wl}) ||
                        (rj_en  && frame_edge && seen));
  assign word      = rj_en ? (sh << shamt) : (full_cur << shamt);
  assign emit_left = rj_en ? lr_prev : (is_i2s ? ~lr_now : lr_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bc_sy       <= '0;
      lr_sy       <= '0;
      d_sy        <= '0;
      lr_prev     <= 1'b0;
      seen        <= 1'b0;
      pos         <= 6'd63;
      sh          <= '0;
      left_valid  <= 1'b0;
      right_valid <= 1'b0;
      left_data   <= '0;
      right_data  <= '0;
    end else begin
      bc_sy       <= {bc_sy[1:0], bclk};
      lr_sy       <= {lr_sy[0], lrck};
      d_sy        <= {d_sy[0], sdata};
      left_valid  <= done & emit_left;
      right_valid <= done & ~emit_left;
      if (done &&  emit_left) left_data  <= word;
      if (done && !emit_left) right_data <= word;
      if (rise) begin
        sh      <= full_cur;
        lr_prev <= lr_now;
        pos     <= pos_now;
        if (frame_edge) seen <= 1'b1;
      end
    end
  end

  p_single_chan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(left_valid && right_valid));
  p_left_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    left_valid |=> !left_valid);
  p_right_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    right_valid |=> !right_valid);
  p_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (left_valid && $past(wl) == 5'd16) |-> left_data[7:0] == 8'd0);
  p_bclk_div_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(bclk_q) |-> $past(div_cnt) == DIVW'(HALF_DIV - 1));
  p_lrck_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(bcnt[5]) |-> $fell(bclk_q));
endmodule

// File: tb/tb_pcm_serial_rx.sv
module tb_pcm_serial_rx;
  localparam int HALF_DIV = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, master_en = 1'b0, clk_hiz = 1'b0, fmt_i2s = 1'b0, rj_en = 1'b0;
  logic [4:0] wlen = 5'd16;
  logic sdata = 1'b0, ext_on = 1'b1, bclk_drv = 1'b0, lrck_drv = 1'b0;
  wire  bclk_w, lrck_w;
  logic [23:0] left_data, right_data;
  logic left_valid, right_valid;

  assign bclk_w = ext_on ? bclk_drv : 1'bz;
  assign lrck_w = ext_on ? lrck_drv : 1'bz;

  pcm_serial_rx #(.HALF_DIV(HALF_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .clk_hiz(clk_hiz),
    .fmt_i2s(fmt_i2s), .rj_en(rj_en), .wlen(wlen), .bclk(bclk_w), .lrck(lrck_w),
    .sdata(sdata), .left_data(left_data), .left_valid(left_valid),
    .right_data(right_data), .right_valid(right_valid));

  typedef struct {
    int          due;
    bit          left;
    logic [23:0] val;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0, n_chk = 0, n_fail = 0;
  bit   chk_en = 1'b0, done_flag = 1'b0;
  int   fmt_cur = 0, w_cur = 16;
  bit   have_prev = 1'b0, prev_lr = 1'b0;
  logic [23:0] prev_word = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      exp_t e;
      bit   hit;
      hit = 1'b0;
      while (q.size() > 0 && q[0].due < cyc) begin
        e = q.pop_front();
        chk(1'b0, {e.tag, " missed strobe"}, 24'h0, e.val);
      end
      if (q.size() > 0 && q[0].due == cyc) begin
        e = q.pop_front();
        hit = 1'b1;
        if (e.left)
          chk(left_valid && !right_valid && left_data == e.val, {e.tag, " left word (R6 R7)"},
              left_valid ? left_data : 24'h0, e.val);
        else
          chk(right_valid && !left_valid && right_data == e.val, {e.tag, " right word (R6 R7)"},
              right_valid ? right_data : 24'h0, e.val);
      end
      if (!hit && (left_valid || right_valid))
        chk(1'b0, "R7 unexpected strobe", {22'h0, left_valid, right_valid}, 24'h0);
    end
  end

  function automatic int eff_w(input logic [4:0] v);
    return (v < 5'd16) ? 16 : ((v > 5'd24) ? 24 : int'(v));
  endfunction

  function automatic logic [23:0] align(input logic [23:0] wd, input int w);
    return wd << (24 - w);
  endfunction

  task automatic send_bit(input bit lr, input bit d, output int rc);
    @(negedge clk);
    bclk_drv = 1'b0; lrck_drv = lr; sdata = d;
    @(negedge clk);
    @(negedge clk);
    bclk_drv = 1'b1;
    rc = cyc;
    @(negedge clk);
  endtask

  task automatic push(input int due, input bit left, input logic [23:0] v, input string tag);
    exp_t e;
    e.due = due; e.left = left; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic send_half(input bit lr);
    logic [31:0] bits;
    logic [23:0] wd;
    int rc;
    bits = $urandom();
    wd = 24'($urandom()) & ((24'h1 << w_cur) - 24'h1);
    for (int p = 0; p < 32; p++) begin
      if (fmt_cur == 0 && p < w_cur) bits[31-p] = wd[w_cur-1-p];
      if (fmt_cur == 1 && p >= 1 && p <= w_cur) bits[31-p] = wd[w_cur-p];
      if (fmt_cur == 2 && p >= 32 - w_cur) bits[31-p] = wd[31-p];
    end
    for (int p = 0; p < 32; p++) begin
      send_bit(lr, bits[31-p], rc);
      if (fmt_cur == 0 && p == w_cur - 1) push(rc + 3, lr, align(wd, w_cur), "R3 left-justified");
      if (fmt_cur == 1 && p == w_cur)     push(rc + 3, !lr, align(wd, w_cur), "R2 i2s");
      if (fmt_cur == 2 && p == 0 && have_prev)
        push(rc + 3, prev_lr, align(prev_word, w_cur), "R4 right-justified");
    end
    prev_word = wd; prev_lr = lr; have_prev = 1'b1;
  endtask

  task automatic do_reset();
    chk_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!left_valid && !right_valid, "R10 no strobe in reset", {22'h0, left_valid, right_valid}, 24'h0);
    rst_n = 1'b1;
  endtask

  task automatic run(input int fmt, input logic [4:0] wl, input int nframes, input bit hiz);
    fmt_cur = fmt; w_cur = eff_w(wl); have_prev = 1'b0;
    q.delete();
    ext_on = 1'b1; bclk_drv = 1'b0; lrck_drv = 1'b0; sdata = 1'b0;
    master_en = hiz; clk_hiz = hiz;
    rj_en = (fmt == 2); fmt_i2s = (fmt == 1); wlen = wl;
    do_reset();
    chk_en = 1'b1;
    repeat (20) @(negedge clk);
    for (int h = 0; h < 2 * nframes + 1; h++) send_half((h % 2) == 0);
    repeat (8) @(negedge clk);
    chk(q.size() == 0, "R1 all expected words seen", 24'(q.size()), 24'h0);
    chk_en = 1'b0;
  endtask

  initial begin
    int last_rise, rises, gap_ok;
    bit pb, pl, saw_high;
    // R10: reset state and idle period before the first frame-clock change
    do_reset();
    chk_en = 1'b1;
    repeat (40) @(negedge clk);
    chk_en = 1'b0;
    run(0, 5'd16, 2, 1'b0);  // R3 R1
    run(0, 5'd24, 2, 1'b0);  // R3 R6
    run(1, 5'd20, 2, 1'b0);  // R2
    run(1, 5'd24, 2, 1'b0);  // R2
    run(2, 5'd16, 2, 1'b0);  // R4
    run(2, 5'd18, 2, 1'b0);  // R4 ignored leading bits
    run(1, 5'd31, 1, 1'b0);  // R5 clamp high
    run(0, 5'd2,  1, 1'b0);  // R5 clamp low
    run(0, 5'd20, 1, 1'b1);  // R9 released clocks, external timing

    // R9: pins stay at the external level while released
    ext_on = 1'b1; bclk_drv = 1'b0; lrck_drv = 1'b0;
    saw_high = 1'b0;
    repeat (30) begin @(negedge clk); if (bclk_w !== 1'b0 || lrck_w !== 1'b0) saw_high = 1'b1; end
    chk(!saw_high, "R9 pins undriven when released", {23'h0, saw_high}, 24'h0);

    // R8: master clock generation
    ext_on = 1'b0; master_en = 1'b1; clk_hiz = 1'b0;
    rj_en = 1'b0; fmt_i2s = 1'b0; wlen = 5'd16; sdata = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(bclk_w === 1'b0 && lrck_w === 1'b0, "R8 clocks low in reset", {22'h0, bclk_w, lrck_w}, 24'h0);
    rst_n = 1'b1;
    pb = 1'b0; pl = 1'b0; last_rise = -1; rises = 0; gap_ok = 1;
    while (!(lrck_w === 1'b1) && rises < 200) begin
      @(negedge clk);
      if (bclk_w === 1'b1 && !pb) begin
        if (last_rise >= 0 && cyc - last_rise != 2 * HALF_DIV) gap_ok = 0;
        last_rise = cyc; rises++;
      end
      pb = (bclk_w === 1'b1);
      if (lrck_w === 1'b1 && pb) gap_ok = 0;
    end
    chk(gap_ok == 1, "R8 bit clock period and frame change on falling edge", 24'(gap_ok), 24'h1);
    chk(rises == 32, "R8 32 bit clocks per frame half", 24'(rises), 24'd32);
    saw_high = 1'b0;
    repeat (400) begin
      @(negedge clk);
      if (left_valid && !saw_high) begin
        saw_high = 1'b1;
        chk(left_data == 24'hFFFF00, "R8 R3 master-mode left word", left_data, 24'hFFFF00);
      end
    end
    chk(saw_high, "R8 master-mode word received", {23'h0, saw_high}, 24'h1);
    pl = 1'b0;

    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete (R1) actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule